// File: doc/BRIEF.md
# Decimating Edge-Trigger Capture Controller

This block sits between a free-running 8-bit sample converter, an external single-port sample RAM and a host register bus. It thins the sample stream by a programmable divide value, which keeps one sample in N. Each kept sample is compared with a host-written threshold. When the signal crosses that threshold in the selected direction, the block fills the whole RAM with consecutive kept samples, starting with the sample that caused the trigger.

The host arms a capture by writing a control word and can abort it at any time. It polls a status word that reports activity, completion and the last RAM address written. The host can also take an interrupt that fires on completion when the interrupt enable is set. The host reaches the RAM through the same block. Its requests are refused while a capture is armed or running, so the host cannot corrupt captured data or collide with the capture write port.

Top module: `scope_capture_ctrl`

## Requirements
- R1: Register map on `host_addr`. Offset 0 holds the trigger level in bits 7:0. Offset 1 is control: write bit0 starts a capture, write bit1 stops it, bit2 selects the falling edge (0 selects rising), and bit3 enables the interrupt. A read of offset 1 returns bit2 and bit3 with the other bits zero. Offset 2 holds the 16-bit divide value. Offset 3 is status. A read returns its value on `host_rdata` one cycle after `host_re`.
- R2: Only the first sample of every N valid samples after a start is used, where N is the divide value. A divide value of 0 or 1 keeps every sample.
- R3: With the rising edge selected, a trigger occurs on a kept sample at or above the level whose previous kept sample since the start was below the level.
- R4: With the falling edge selected, a trigger occurs on a kept sample below the level whose previous kept sample was at or above the level.
- R5: The triggering kept sample is written to address 0. Every following kept sample goes to the next address, one RAM write per kept sample.
- R6: A capture performs exactly 2^ADDR_W writes and then ends, with no wrap to address 0.
- R7: Status bit0 is busy (armed or capturing) and bit1 is done. Bits ADDR_W+1:2 hold the last address written. Reading status clears done and the interrupt.
- R8: `irq` rises after a capture ends only if the interrupt enable is set. It stays low when the enable is clear.
- R9: A host RAM request while busy is answered with `hram_nak` one cycle later and causes no RAM write or read. When the block is not busy, the request is answered with `hram_ack` and forwarded to `ram_we`/`ram_re`/`ram_addr` one cycle later.
- R10: A stop command returns the block to idle from any state. No further capture writes occur and busy and done read 0.
- R11: After reset, `irq`, `ram_we`, `ram_re` and `host_rdata` are 0 and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_valid | input | 1 | A new converter sample is present |
| adc_data | input | DATA_W | Converter sample |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe |
| host_addr | input | 2 | Register offset |
| host_wdata | input | REG_W | Register write data |
| host_rdata | output | REG_W | Register read data, one cycle after read |
| hram_req | input | 1 | Host RAM access request |
| hram_we | input | 1 | Host RAM request is a write |
| hram_addr | input | ADDR_W | Host RAM address |
| hram_wdata | input | DATA_W | Host RAM write data |
| hram_ack | output | 1 | Host request accepted |
| hram_nak | output | 1 | Host request refused (capture active) |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| irq | output | 1 | Capture-complete interrupt |

## Verification
A sample presented on `adc_data` passes three register stages: the decimator, the edge detector and the RAM port. If it is written, it shows up on `ram_we` at the third rising edge after it is presented. The bench does not sample at fixed cycles for this. It logs every RAM write in order and compares the log against a triangle-wave model that computes the kept set, the trigger point and the fill order arithmetically for each edge and divide value. Host register reads and host RAM responses are due one edge after the request, and the bench samples them one nanosecond after that edge. The interrupt follows done by one further edge and is sampled only after the capture has settled.

// File: rtl/scope_pkg.sv
`timescale 1ns/1ps
package scope_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;

  localparam logic [1:0] OFS_LEVEL  = 2'd0;
  localparam logic [1:0] OFS_CTRL   = 2'd1;
  localparam logic [1:0] OFS_DIV    = 2'd2;
  localparam logic [1:0] OFS_STATUS = 2'd3;
endpackage

// File: rtl/scope_decim.sv
`timescale 1ns/1ps
module scope_decim #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [DIV_W-1:0] cnt;
  logic             unit_div;
  logic             keep;

  assign unit_div = (div_val <= DIV_W'(1));
  assign keep     = in_valid && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= keep;
      if (keep) out_data <= in_data;
      if (in_valid) begin
        if (unit_div || cnt >= div_val - 1'b1) cnt <= '0;
        else                                   cnt <= cnt + 1'b1;
      end
    end
  end

  // two kept samples in a row only when every sample is kept
  AST_DECIM_SPACING: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> (!out_valid || unit_div)); // R2
endmodule

// File: rtl/scope_trig.sv
`timescale 1ns/1ps
module scope_trig #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [DATA_W-1:0] level,
  input  logic              fall_sel,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              s_valid,
  output logic [DATA_W-1:0] s_data,
  output logic              hit
);
  logic              have_prev;
  logic [DATA_W-1:0] prev;
  logic              up_x, down_x;

  assign up_x   = (prev <  level) && (in_data >= level);
  assign down_x = (prev >= level) && (in_data <  level);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      have_prev <= 1'b0;
      prev      <= '0;
      s_valid   <= 1'b0;
      s_data    <= '0;
      hit       <= 1'b0;
    end else begin
      s_valid <= in_valid;
      hit     <= in_valid && have_prev && (fall_sel ? down_x : up_x);
      if (in_valid) begin
        prev      <= in_data;
        have_prev <= 1'b1;
        s_data    <= in_data;
      end
    end
  end

  AST_HIT_SIDE: assert property (@(posedge clk) disable iff (rst)
    hit && $stable(level) && $stable(fall_sel)
      |-> (fall_sel ? (s_data < level) : (s_data >= level))); // R3
endmodule

// File: rtl/scope_fsm.sv
`timescale 1ns/1ps
module scope_fsm
  import scope_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              s_valid,
  input  logic              hit,
  output cap_state_e        state,
  output logic              arm,
  output logic              cap_wr,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              done_pulse
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  assign arm        = start && !stop && (state == ST_IDLE || state == ST_DONE);
  assign cap_wr     = s_valid && ((state == ST_ARMED && hit) || state == ST_CAPT);
  assign done_pulse = cap_wr && (cap_addr == LAST) && !stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cap_addr <= '0;
    end else if (stop) begin
      state <= ST_IDLE;
    end else if (arm) begin
      state    <= ST_ARMED;
      cap_addr <= '0;
    end else if (cap_wr) begin
      cap_addr <= cap_addr + 1'b1;
      state    <= (cap_addr == LAST) ? ST_DONE : ST_CAPT;
    end
  end

  AST_FILL_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
    cap_wr && cap_addr == LAST && !stop |=> state == ST_DONE); // R6
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    stop |=> state == ST_IDLE); // R10
  AST_ARMED_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    state == ST_ARMED |-> cap_addr == '0); // R5
endmodule

// File: rtl/scope_capture_ctrl.sv
`timescale 1ns/1ps
module scope_capture_ctrl
  import scope_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 14,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adc_valid,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [1:0]        host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  input  logic              hram_req,
  input  logic              hram_we,
  input  logic [ADDR_W-1:0] hram_addr,
  input  logic [DATA_W-1:0] hram_wdata,
  output logic              hram_ack,
  output logic              hram_nak,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic              ram_re,
  output logic              irq
);
  logic [DATA_W-1:0] level_q;
  logic [REG_W-1:0]  div_q;
  logic              fall_q, irqen_q, done_q;
  logic [ADDR_W-1:0] last_q;
  logic              wr_ctrl, start_cmd, stop_cmd, stat_rd, busy;
  logic              k_valid, s_valid, hit, arm, cap_wr, done_pulse;
  logic [DATA_W-1:0] k_data, s_data;
  logic [ADDR_W-1:0] cap_addr;
  cap_state_e        state;

  assign wr_ctrl   = host_we && host_addr == OFS_CTRL;
  assign start_cmd = wr_ctrl && host_wdata[0];
  assign stop_cmd  = wr_ctrl && host_wdata[1];
  assign stat_rd   = host_re && host_addr == OFS_STATUS;
  assign busy      = (state == ST_ARMED) || (state == ST_CAPT);

  scope_decim #(.DATA_W(DATA_W), .DIV_W(REG_W)) u_decim (
    .clk(clk), .rst(rst), .restart(arm), .div_val(div_q),
    .in_valid(adc_valid), .in_data(adc_data),
    .out_valid(k_valid), .out_data(k_data));

  scope_trig #(.DATA_W(DATA_W)) u_trig (
    .clk(clk), .rst(rst), .restart(arm), .level(level_q), .fall_sel(fall_q),
    .in_valid(k_valid), .in_data(k_data),
    .s_valid(s_valid), .s_data(s_data), .hit(hit));

  scope_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start_cmd), .stop(stop_cmd),
    .s_valid(s_valid), .hit(hit), .state(state), .arm(arm),
    .cap_wr(cap_wr), .cap_addr(cap_addr), .done_pulse(done_pulse));

  // host registers, status and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      level_q    <= '0;
      div_q      <= '0;
      fall_q     <= 1'b0;
      irqen_q    <= 1'b0;
      done_q     <= 1'b0;
      last_q     <= '0;
      irq        <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (host_we && host_addr == OFS_LEVEL) level_q <= host_wdata[DATA_W-1:0];
      if (host_we && host_addr == OFS_DIV)   div_q   <= host_wdata;
      if (wr_ctrl) begin
        fall_q  <= host_wdata[2];
        irqen_q <= host_wdata[3];
      end
      if (cap_wr) last_q <= cap_addr;
      if (done_pulse)                       done_q <= 1'b1;
      else if (stat_rd || arm || stop_cmd)  done_q <= 1'b0;
      irq <= done_q && irqen_q && !stat_rd;
      if (host_re) begin
        case (host_addr)
          OFS_LEVEL: host_rdata <= REG_W'(level_q);
          OFS_CTRL:  host_rdata <= REG_W'({irqen_q, fall_q, 2'b00});
          OFS_DIV:   host_rdata <= div_q;
          default:   host_rdata <= REG_W'({last_q, done_q, busy});
        endcase
      end
    end
  end

  // RAM port arbitration: capture owns the RAM while busy
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      hram_ack  <= 1'b0;
      hram_nak  <= 1'b0;
    end else begin
      hram_ack <= hram_req && !busy;
      hram_nak <= hram_req && busy;
      if (busy) begin
        ram_we    <= cap_wr;
        ram_re    <= 1'b0;
        ram_addr  <= cap_addr;
        ram_wdata <= s_data;
      end else begin
        ram_we    <= hram_req && hram_we;
        ram_re    <= hram_req && !hram_we;
        ram_addr  <= hram_addr;
        ram_wdata <= hram_wdata;
      end
    end
  end

  AST_HOST_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    hram_req && busy |=> hram_nak && !hram_ack && !ram_re); // R9
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    busy && !cap_wr |=> !ram_we); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irqen_q)); // R8
endmodule

// File: tb/scope_capture_ctrl_tb.sv
`timescale 1ns/1ps
module scope_capture_ctrl_tb;
  localparam int DW = 8, AW = 4, RW = 16, DEPTH = 1 << AW, LVL = 100;

  logic clk = 0, rst = 1;
  logic adc_valid = 0; logic [DW-1:0] adc_data = 0;
  logic host_we = 0, host_re = 0; logic [1:0] host_addr = 0;
  logic [RW-1:0] host_wdata = 0; logic [RW-1:0] host_rdata;
  logic hram_req = 0, hram_we = 0; logic [AW-1:0] hram_addr = 0;
  logic [DW-1:0] hram_wdata = 0;
  logic hram_ack, hram_nak, ram_we, ram_re, irq;
  logic [AW-1:0] ram_addr; logic [DW-1:0] ram_wdata;

  int n_chk = 0, n_bad = 0;
  logic log_clr = 0;
  int log_n = 0;
  logic [AW-1:0] log_a [64];
  logic [DW-1:0] log_d [64];

  always #2.5 clk = ~clk;

  scope_capture_ctrl #(.DATA_W(DW), .ADDR_W(AW), .REG_W(RW)) u_dut (
    .clk(clk), .rst(rst), .adc_valid(adc_valid), .adc_data(adc_data),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .hram_req(hram_req), .hram_we(hram_we), .hram_addr(hram_addr),
    .hram_wdata(hram_wdata), .hram_ack(hram_ack), .hram_nak(hram_nak),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_re(ram_re), .irq(irq));

  always @(posedge clk) begin
    if (log_clr) log_n <= 0;
    else if (ram_we) begin
      if (log_n < 64) begin log_a[log_n] <= ram_addr; log_d[log_n] <= ram_wdata; end
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  function automatic int wave(input int j);
    int t = j % 64;
    return (t < 32) ? t * 8 : (63 - t) * 8;
  endfunction

  function automatic int trig_idx(input bit fall, input int eff);
    for (int j = eff; j < 2000; j += eff) begin
      int p = wave(j - eff), c = wave(j);
      if (!fall && p < LVL && c >= LVL) return j;
      if (fall && p >= LVL && c < LVL) return j;
    end
    return -1;
  endfunction

  task automatic reg_wr(input logic [1:0] a, input int d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = RW'(d);
    @(negedge clk); host_we = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output int d);
    @(negedge clk); host_re = 1; host_addr = a;
    @(posedge clk); #1 d = int'(host_rdata);
    @(negedge clk); host_re = 0;
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1; @(negedge clk); log_clr = 0;
  endtask

  task automatic stream(input int first, input int cnt);
    for (int j = first; j < first + cnt; j++) begin
      @(negedge clk); adc_valid = 1; adc_data = DW'(wave(j));
    end
    @(negedge clk); adc_valid = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic host_ram(input bit we, input int a, output bit ack, output bit nak,
                          output bit rwe, output bit rre, output int ra);
    @(negedge clk); hram_req = 1; hram_we = we; hram_addr = AW'(a); hram_wdata = 8'h5A;
    @(posedge clk); #1 ack = hram_ack; nak = hram_nak; rwe = ram_we; rre = ram_re; ra = int'(ram_addr);
    @(negedge clk); hram_req = 0;
  endtask

  task automatic run_capture(input bit fall, input int div, input bit mask, input bit probe);
    int eff = (div <= 1) ? 1 : div;
    int jt = trig_idx(fall, eff);
    int st, ok_all;
    bit ack, nak, rwe, rre; int ra;
    reg_wr(2'd0, LVL);
    reg_wr(2'd2, div);
    clear_log();
    reg_wr(2'd1, 1 | (int'(fall) << 2) | (int'(mask) << 3));
    if (probe) begin
      host_ram(1'b1, 3, ack, nak, rwe, rre, ra);
      chk(nak && !ack && !rwe && !rre, "R9 refused while armed", {ack, nak, rwe}, 3'b010);
      reg_rd(2'd3, st);
      chk((st & 3) == 1, "R7 busy while armed", st & 3, 1);
    end
    stream(0, jt + DEPTH * eff + 20);
    chk(log_n == DEPTH, $sformatf("R6 write count fall=%0d div=%0d", fall, div), log_n, DEPTH);
    ok_all = 1;
    for (int a = 0; a < DEPTH && a < log_n; a++) begin
      if (int'(log_a[a]) != a || int'(log_d[a]) != wave(jt + a * eff)) begin
        ok_all = 0;
        $display("FAIL %s addr=%0d actual=%0d/%0d expected=%0d/%0d",
                 fall ? "R4 R2 R5" : "R3 R2 R5", a, log_a[a], log_d[a], a, wave(jt + a * eff));
      end
    end
    n_chk++; if (!ok_all) n_bad++;
    chk(irq == mask, "R8 irq follows enable", irq, mask);
    reg_rd(2'd3, st);
    chk(st == ((DEPTH - 1) << 2 | 2), "R7 status after capture", st, (DEPTH - 1) << 2 | 2);
    @(negedge clk); @(negedge clk);
    chk(irq == 0, "R7 irq cleared by status read", irq, 0);
    reg_rd(2'd3, st);
    chk((st & 3) == 0, "R7 done cleared by read", st & 3, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, n0; bit ack, nak, rwe, rre; int ra;
    repeat (4) @(negedge clk); rst = 0;
    @(negedge clk);
    chk(irq == 0 && ram_we == 0 && ram_re == 0 && host_rdata == 0, "R11 reset outputs",
        {irq, ram_we, ram_re}, 0);
    reg_rd(2'd3, v); chk(v == 0, "R11 status after reset", v, 0);

    reg_wr(2'd0, 8'hA7); reg_rd(2'd0, v); chk(v == 8'hA7, "R1 level readback", v, 8'hA7);
    reg_wr(2'd2, 16'h1234); reg_rd(2'd2, v); chk(v == 16'h1234, "R1 divide readback", v, 16'h1234);
    reg_wr(2'd1, 4'b1100); reg_rd(2'd1, v); chk(v == 4'b1100, "R1 control readback", v, 4'b1100);
    reg_wr(2'd1, 0);

    host_ram(1'b1, 9, ack, nak, rwe, rre, ra);
    chk(ack && !nak && rwe && !rre && ra == 9, "R9 idle write accepted", {ack, nak, rwe, rre}, 4'b1010);
    host_ram(1'b0, 6, ack, nak, rwe, rre, ra);
    chk(ack && !nak && !rwe && rre && ra == 6, "R9 idle read accepted", {ack, nak, rwe, rre}, 4'b1001);

    for (int fall = 0; fall < 2; fall++)
      for (int div = 0; div < 5; div++)
        run_capture(fall[0], div, div[0], div == 2);

    // stop during capture
    reg_wr(2'd0, LVL); reg_wr(2'd2, 1); clear_log();
    reg_wr(2'd1, 1);
    stream(0, 20);
    n0 = log_n;
    chk(n0 > 0 && n0 < DEPTH, "R10 capture in progress before stop", n0, 5);
    reg_wr(2'd1, 2);
    stream(20, 60);
    chk(log_n == n0, "R10 no writes after stop", log_n, n0);
    reg_rd(2'd3, v); chk((v & 3) == 0, "R10 idle after stop", v & 3, 0);

    // stop while armed (level never crossed)
    reg_wr(2'd0, 255); clear_log();
    reg_wr(2'd1, 1);
    reg_rd(2'd3, v); chk((v & 1) == 1, "R10 armed before stop", v & 1, 1);
    reg_wr(2'd1, 2);
    reg_rd(2'd3, v); chk((v & 3) == 0, "R10 idle after stop from armed", v & 3, 0);
    chk(log_n == 0, "R3 no trigger without crossing", log_n, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule